// File: doc/BRIEF.md
# Fragmented line DMA address generator

This block sits behind the descriptor fetch of a display DMA engine. It turns the fields of one descriptor into a stream of memory read requests for the pixel payload. Each request is an address and a byte count, with flags that mark fragment, line and descriptor ends. A single mode bit chooses one of two payload layouts.

In contiguous mode the payload is a run of lines. The first line starts at fragment slot 0, and each later line starts one stride beyond the one before. In fragmented mode the payload is a single line scattered over up to five page-bounded pieces of memory. Each piece starts at its own 256-byte aligned address and runs to the next 4 KB boundary or to the end of the line, whichever comes first. How many pieces are used follows from the line size alone.

All descriptor rules are checked in the cycle the start strobe is taken. A descriptor that breaks a rule produces an error pulse and no requests at all.

Top module: `frag_line_agen`

## Requirements
- R1: With `mode_i`=0 (contiguous), line k (k counted from 0) covers `line_bytes_i` bytes starting at `frag_addr_i[0]` + k·`stride_i`.
- R2: In contiguous mode exactly `line_cnt_i` lines are issued. A line count of 0, or one larger than `frame_lines_i`, is an error.
- R3: With `mode_i`=1 (fragmented), exactly one line is issued. Fragment k starts at `frag_addr_i[k]` and ends at the next 4 KB boundary or when the line's remaining bytes run out, whichever is first.
- R4: Only the fragments needed to cover the line size are used. Unused slots are ignored, even when misaligned.
- R5: In fragmented mode, a used fragment address with any of bits [7:0] set gives an error and no requests.
- R6: A line size of 0 or above 20480 bytes is an error in either mode. A line size of exactly 20480 is legal.
- R7: In fragmented mode, if five fragments cannot cover the line size, the result is an error and no requests.
- R8: Every request carries 1 to 256 bytes and never crosses a 4 KB boundary. Within a fragment or line, requests are back to back, and each is as long as those limits and the remaining bytes allow.
- R9: `req_eof_o` marks the last request of each fragment (in contiguous mode, each line counts as one fragment). `req_eol_o` marks the last request of a line. `req_eod_o` marks the final request, after which the block goes idle with no request pending.
- R10: While `req_valid_o` is high and `req_ready_i` is low, the request and its flags stay unchanged.
- R11: `err_o` is a one-cycle pulse in the cycle after a rejected start. A start seen while requests are in progress is ignored, and so are changes to the descriptor inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken when idle |
| mode_i | input | 1 | 0 = contiguous lines, 1 = fragmented single line |
| line_bytes_i | input | LEN_W | Line size in bytes |
| stride_i | input | ADDR_W | Distance between line starts (contiguous) |
| line_cnt_i | input | CNT_W | Lines in this descriptor (contiguous) |
| frame_lines_i | input | CNT_W | Lines in one frame, upper bound on line count |
| frag_addr_i | input | NUM_FRAG×ADDR_W | Fragment start addresses; slot 0 is also the contiguous base |
| req_ready_i | input | 1 | Request accepted by consumer |
| req_valid_o | output | 1 | Request valid |
| req_addr_o | output | ADDR_W | Request byte address |
| req_len_o | output | BURST_W+1 | Request byte count |
| req_eof_o | output | 1 | Last request of a fragment |
| req_eol_o | output | 1 | Last request of a line |
| req_eod_o | output | 1 | Last request of the descriptor |
| err_o | output | 1 | Descriptor rule violation pulse |

## Verification
The assertions take for granted that `start_i` is pulsed only while the block is idle, or, if it is raised mid-stream, that it is dropped before the final request. They also assume the consumer sees a request only through the valid/ready pair. The bench raises start for one cycle per descriptor, with a single deliberate mid-stream pulse to exercise R11. It pulls ready with a fixed per-case duty pattern so that stalls land on every kind of request, and it checks error cases only in the idle gap that follows each rejected start.

// File: rtl/frag_agen_pkg.sv
package frag_agen_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} agen_st_e;
endpackage

// File: rtl/frag_plan.sv
// Decides which fragments a line needs and whether they are legal.
module frag_plan #(
  parameter int LEN_W    = 16,
  parameter int NUM_FRAG = 5,
  parameter int PAGE_W   = 12,
  parameter int ALIGN_W  = 8
) (
  input  logic [NUM_FRAG-1:0][PAGE_W-1:0] frag_off_i,
  input  logic [LEN_W-1:0]                line_bytes_i,
  output logic                            align_err_o,
  output logic                            short_err_o
);
  localparam int PAGE  = 2 ** PAGE_W;
  localparam int ACC_W = PAGE_W + $clog2(NUM_FRAG + 1) + 1;
  localparam int CW    = ((ACC_W > LEN_W) ? ACC_W : LEN_W) + 1;

  logic [NUM_FRAG:0][ACC_W-1:0] acc;
  logic [NUM_FRAG-1:0]          used, bad;

  assign acc[0] = '0;
  for (genvar g = 0; g < NUM_FRAG; g++) begin : g_frag
    logic [PAGE_W:0] room;
    assign room       = (PAGE_W + 1)'(PAGE) - {1'b0, frag_off_i[g]};
    assign acc[g+1]   = acc[g] + ACC_W'(room);
    assign used[g]    = CW'(acc[g]) < CW'(line_bytes_i);
    assign bad[g]     = used[g] && (frag_off_i[g][ALIGN_W-1:0] != '0);
  end

  assign align_err_o = |bad;
  assign short_err_o = CW'(acc[NUM_FRAG]) < CW'(line_bytes_i);
endmodule

// File: rtl/burst_cut.sv
// Length of the next request: min(remaining, burst, room left in page).
module burst_cut #(
  parameter int LEN_W   = 16,
  parameter int PAGE_W  = 12,
  parameter int BURST_W = 8
) (
  input  logic [PAGE_W-1:0]  page_off_i,
  input  logic [LEN_W-1:0]   rem_i,
  output logic [BURST_W:0]   len_o
);
  localparam int PAGE  = 2 ** PAGE_W;
  localparam int BURST = 2 ** BURST_W;
  localparam int W     = (LEN_W > PAGE_W + 1) ? LEN_W : PAGE_W + 1;

  logic [PAGE_W:0] room;
  logic [W-1:0]    m1;

  always_comb begin
    room  = (PAGE_W + 1)'(PAGE) - {1'b0, page_off_i};
    m1    = (W'(rem_i) < W'(room)) ? W'(rem_i) : W'(room);
    len_o = (m1 < W'(BURST)) ? (BURST_W + 1)'(m1) : (BURST_W + 1)'(BURST);
  end
endmodule

// File: rtl/frag_line_agen.sv
module frag_line_agen
  import frag_agen_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 16,
  parameter int CNT_W    = 12,
  parameter int NUM_FRAG = 5,
  parameter int PAGE_W   = 12,
  parameter int BURST_W  = 8,
  parameter int MAX_LINE = 20480
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            start_i,
  input  logic                            mode_i,
  input  logic [LEN_W-1:0]                line_bytes_i,
  input  logic [ADDR_W-1:0]               stride_i,
  input  logic [CNT_W-1:0]                line_cnt_i,
  input  logic [CNT_W-1:0]                frame_lines_i,
  input  logic [NUM_FRAG-1:0][ADDR_W-1:0] frag_addr_i,
  input  logic                            req_ready_i,
  output logic                            req_valid_o,
  output logic [ADDR_W-1:0]               req_addr_o,
  output logic [BURST_W:0]                req_len_o,
  output logic                            req_eof_o,
  output logic                            req_eol_o,
  output logic                            req_eod_o,
  output logic                            err_o
);
  localparam int PAGE = 2 ** PAGE_W;
  localparam int FI_W = (NUM_FRAG > 1) ? $clog2(NUM_FRAG) : 1;

  agen_st_e                        state_q;
  logic                            err_q;
  logic [NUM_FRAG-1:0][ADDR_W-1:0] frag_q;
  logic [ADDR_W-1:0]               stride_q, cur_addr_q, line_start_q;
  logic [LEN_W-1:0]                line_bytes_q, line_rem_q, seg_rem_q;
  logic [CNT_W-1:0]                lines_left_q;
  logic [FI_W-1:0]                 frag_idx_q, nidx;
  logic [NUM_FRAG-1:0][PAGE_W-1:0] frag_off;
  logic                            align_err, short_err, cfg_err;
  logic [BURST_W:0]                req_len;
  logic [LEN_W-1:0]                len_ext;
  logic                            last_seg, last_line, last_desc;

  function automatic logic [LEN_W-1:0] seg_len(input logic [PAGE_W-1:0] off,
                                               input logic [LEN_W-1:0]  rem);
    logic [PAGE_W:0] room;
    room = (PAGE_W + 1)'(PAGE) - {1'b0, off};
    return (LEN_W'(room) < rem) ? LEN_W'(room) : rem;
  endfunction

  for (genvar g = 0; g < NUM_FRAG; g++) begin : g_off
    assign frag_off[g] = frag_addr_i[g][PAGE_W-1:0];
  end

  frag_plan #(
    .LEN_W(LEN_W), .NUM_FRAG(NUM_FRAG), .PAGE_W(PAGE_W), .ALIGN_W(BURST_W)
  ) u_plan (
    .frag_off_i  (frag_off),
    .line_bytes_i(line_bytes_i),
    .align_err_o (align_err),
    .short_err_o (short_err)
  );

  burst_cut #(
    .LEN_W(LEN_W), .PAGE_W(PAGE_W), .BURST_W(BURST_W)
  ) u_cut (
    .page_off_i(cur_addr_q[PAGE_W-1:0]),
    .rem_i     (seg_rem_q),
    .len_o     (req_len)
  );

  always_comb begin
    cfg_err = (line_bytes_i == '0) || (line_bytes_i > LEN_W'(MAX_LINE));
    if (mode_i) cfg_err = cfg_err || align_err || short_err;
    else        cfg_err = cfg_err || (line_cnt_i == '0) || (line_cnt_i > frame_lines_i);
    len_ext   = LEN_W'(req_len);
    last_seg  = (len_ext == seg_rem_q);
    last_line = (len_ext == line_rem_q);
    last_desc = last_line && (lines_left_q == CNT_W'(1));
    nidx      = (frag_idx_q == FI_W'(NUM_FRAG - 1)) ? frag_idx_q : frag_idx_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      err_q        <= 1'b0;
      frag_q       <= '0;
      stride_q     <= '0;
      cur_addr_q   <= '0;
      line_start_q <= '0;
      line_bytes_q <= '0;
      line_rem_q   <= '0;
      seg_rem_q    <= '0;
      lines_left_q <= '0;
      frag_idx_q   <= '0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (cfg_err) begin
            err_q <= 1'b1;
          end else begin
            state_q      <= ST_RUN;
            frag_q       <= frag_addr_i;
            stride_q     <= stride_i;
            line_bytes_q <= line_bytes_i;
            lines_left_q <= mode_i ? CNT_W'(1) : line_cnt_i;
            frag_idx_q   <= '0;
            cur_addr_q   <= frag_addr_i[0];
            line_start_q <= frag_addr_i[0];
            line_rem_q   <= line_bytes_i;
            seg_rem_q    <= mode_i ? seg_len(frag_off[0], line_bytes_i) : line_bytes_i;
          end
        end
        ST_RUN: if (req_ready_i) begin
          if (last_desc) begin
            state_q <= ST_IDLE;
          end else if (last_line) begin
            // contiguous only: next line one stride on
            lines_left_q <= lines_left_q - 1'b1;
            line_start_q <= line_start_q + stride_q;
            cur_addr_q   <= line_start_q + stride_q;
            line_rem_q   <= line_bytes_q;
            seg_rem_q    <= line_bytes_q;
          end else if (last_seg) begin
            frag_idx_q <= nidx;
            cur_addr_q <= frag_q[nidx];
            line_rem_q <= line_rem_q - len_ext;
            seg_rem_q  <= seg_len(frag_q[nidx][PAGE_W-1:0], line_rem_q - len_ext);
          end else begin
            cur_addr_q <= cur_addr_q + ADDR_W'(req_len);
            line_rem_q <= line_rem_q - len_ext;
            seg_rem_q  <= seg_rem_q - len_ext;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid_o = (state_q == ST_RUN);
  assign req_addr_o  = cur_addr_q;
  assign req_len_o   = req_len;
  assign req_eof_o   = req_valid_o && last_seg;
  assign req_eol_o   = req_valid_o && last_line;
  assign req_eod_o   = req_valid_o && last_desc;
  assign err_o       = err_q;
endmodule

// File: rtl/frag_line_agen_chk.sv
module frag_line_agen_chk #(
  parameter int PAGE_W  = 12,
  parameter int BURST_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_i,
  input logic              req_valid_i,
  input logic [PAGE_W-1:0] addr_lo_i,
  input logic [BURST_W:0]  req_len_i,
  input logic              req_eof_i,
  input logic              req_eol_i,
  input logic              req_eod_i,
  input logic              err_i
);
  localparam int PAGE  = 2 ** PAGE_W;
  localparam int BURST = 2 ** BURST_W;
  localparam int SW    = PAGE_W + 2;

  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (req_len_i != '0) && (req_len_i <= (BURST_W + 1)'(BURST))); // R8
  AST_NO_PAGE_CROSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (SW'(addr_lo_i) + SW'(req_len_i)) <= SW'(PAGE)); // R8
  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_ready_i |=> req_valid_i && $stable(addr_lo_i) && $stable(req_len_i)
      && $stable({req_eof_i, req_eol_i, req_eod_i})); // R10
  AST_FLAG_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && (req_eod_i || req_eol_i) |-> req_eof_i && (req_eol_i || !req_eod_i)); // R9
  AST_IDLE_AFTER_EOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_i && req_eod_i |=> !req_valid_i); // R9
  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> !req_valid_i); // R5
endmodule

bind frag_line_agen frag_line_agen_chk #(.PAGE_W(PAGE_W), .BURST_W(BURST_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_i(req_ready_i),
  .req_valid_i(req_valid_o),
  .addr_lo_i  (req_addr_o[PAGE_W-1:0]),
  .req_len_i  (req_len_o),
  .req_eof_i  (req_eof_o),
  .req_eol_i  (req_eol_o),
  .req_eod_i  (req_eod_o),
  .err_i      (err_o)
);

// File: tb/frag_line_agen_bench.sv
module frag_line_agen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 5;
  localparam int MAXQ = 1024;

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0, mode = 1'b0, ready = 1'b0;
  logic [15:0] line_bytes = '0;
  logic [31:0] stride = '0;
  logic [11:0] line_cnt = '0, frame_lines = '0;
  logic [NF-1:0][31:0] fa = '0;
  logic req_valid, req_eof, req_eol, req_eod, err;
  logic [31:0] req_addr;
  logic [8:0] req_len;

  frag_line_agen u_frag_line_agen (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .mode_i(mode),
    .line_bytes_i(line_bytes), .stride_i(stride), .line_cnt_i(line_cnt),
    .frame_lines_i(frame_lines), .frag_addr_i(fa), .req_ready_i(ready),
    .req_valid_o(req_valid), .req_addr_o(req_addr), .req_len_o(req_len),
    .req_eof_o(req_eof), .req_eol_o(req_eol), .req_eod_o(req_eod), .err_o(err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] e_addr[MAXQ];
  int e_len[MAXQ];
  logic [2:0] e_flg[MAXQ];
  int e_n;
  bit e_err;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] a, input int l, input logic [2:0] f);
    if (e_n < MAXQ) begin
      e_addr[e_n] = a; e_len[e_n] = l; e_flg[e_n] = f;
    end
    e_n++;
  endtask

  // Expected stream built from the requirements only.
  task automatic model(input bit md, input int line, input logic [31:0] strd,
                       input int cnt, input int frame, input logic [NF-1:0][31:0] f);
    int rem, seg, len, room;
    logic [31:0] a;
    e_n = 0;
    e_err = (line == 0) || (line > 20480);
    if (!md) e_err = e_err || (cnt == 0) || (cnt > frame);
    else begin
      rem = line;
      for (int k = 0; k < NF; k++) begin
        if (rem > 0) begin
          if (f[k][7:0] != 0) e_err = 1;
          room = 4096 - int'(f[k][11:0]);
          rem -= (rem < room) ? rem : room;
        end
      end
      if (rem > 0) e_err = 1;
    end
    if (e_err) return;
    if (!md) begin
      for (int ln = 0; ln < cnt; ln++) begin
        a = f[0] + strd * ln;
        rem = line;
        while (rem > 0) begin
          room = 4096 - int'(a[11:0]);
          len = rem < 256 ? rem : 256;
          if (room < len) len = room;
          push(a, len, {len == rem && ln == cnt - 1, len == rem, len == rem});
          a += len; rem -= len;
        end
      end
    end else begin
      rem = line;
      for (int k = 0; k < NF && rem > 0; k++) begin
        a = f[k];
        room = 4096 - int'(a[11:0]);
        seg = rem < room ? rem : room;
        while (seg > 0) begin
          len = seg < 256 ? seg : 256;
          push(a, len, {len == rem, len == rem, len == seg});
          a += len; seg -= len; rem -= len;
        end
      end
    end
  endtask

  task automatic run_case(input string tag, input bit md, input int line,
                          input logic [31:0] strd, input int cnt, input int frame,
                          input logic [NF-1:0][31:0] f, input int seed, input bit poke);
    int got, cyc;
    bit done, held;
    logic [31:0] h_addr;
    logic [8:0] h_len;
    model(md, line, strd, cnt, frame, f);
    @(negedge clk);
    mode = md; line_bytes = 16'(line); stride = strd; line_cnt = 12'(cnt);
    frame_lines = 12'(frame); fa = f; start = 1'b1; ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(err == e_err, tag, "error flag after start", err, e_err);
    chk(req_valid == !e_err, tag, "valid after start", req_valid, !e_err);
    if (e_err) begin
      @(negedge clk); #1;
      chk(err == 1'b0, "R11", "error pulse width", err, 0);
      for (int i = 0; i < 3; i++) begin
        chk(req_valid == 1'b0, tag, "no request after error", req_valid, 0);
        @(negedge clk); #1;
      end
      return;
    end
    got = 0; cyc = 0; done = 0; held = 0;
    while (!done && cyc < 20000) begin
      ready = (seed == 0) ? 1'b1 : (((cyc * seed) % 4) != 3);
      if (poke && cyc == 2) begin
        start = 1'b1; mode = ~md; line_bytes = 16'd7; stride = 32'h44; fa = '1;
      end
      if (poke && cyc == 3) start = 1'b0;
      #1;
      if (held)
        chk(req_valid && req_addr == h_addr && req_len == h_len, "R10", "stalled request held",
            {req_addr, 7'd0, req_len}, {h_addr, 7'd0, h_len});
      held = req_valid && !ready;
      h_addr = req_addr; h_len = req_len;
      if (req_valid && ready) begin
        if (got < e_n && got < MAXQ) begin
          chk(req_addr == e_addr[got] && int'(req_len) == e_len[got], tag,
              $sformatf("req %0d addr/len", got),
              {req_addr, 16'(req_len)}, {e_addr[got], 16'(e_len[got])});
          chk({req_eod, req_eol, req_eof} == e_flg[got], "R9",
              $sformatf("req %0d eod/eol/eof", got), {req_eod, req_eol, req_eof}, e_flg[got]);
        end
        got++;
        if (req_eod) done = 1;
      end
      @(negedge clk);
      cyc++;
    end
    chk(got == e_n, poke ? "R11" : "R9", "request count", got, e_n);
    ready = 1'b0;
    #1;
    chk(req_valid == 1'b0, "R9", "idle after final request", req_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [NF-1:0][31:0] f;
    int offs[4] = '{0, 'h100, 'hA00, 'hF00};
    int lines[7] = '{1, 256, 300, 1552, 4096, 10240, 20480};
    repeat (3) @(negedge clk);
    #1;
    chk(req_valid == 0 && err == 0, "R9", "reset state", {req_valid, err}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // contiguous
    f = '0; f[0] = 32'h1000;
    run_case("R1", 0, 1024, 32'h800, 3, 4, f, 0, 0);
    f[0] = 32'h1F80;
    run_case("R1", 0, 1000, 32'h3000, 2, 2, f, 3, 1);
    f[0] = 32'h0020;
    run_case("R2", 0, 700, 32'h2C0, 4, 4, f, 5, 0);
    run_case("R2", 0, 700, 32'h2C0, 0, 4, f, 0, 0);
    run_case("R2", 0, 700, 32'h2C0, 5, 4, f, 0, 0);
    run_case("R6", 0, 0, 32'h100, 1, 4, f, 0, 0);

    // fragmented sweep over first-fragment offset and line size
    foreach (offs[i]) foreach (lines[j]) begin
      f[0] = 32'h0000_A000 + 32'(offs[i]);
      for (int k = 1; k < NF; k++) f[k] = 32'h0001_0000 * (k + 1) + ((k == 2) ? 32'h800 : 32'h0);
      run_case("R3", 1, lines[j], 32'h0, 0, 0, f, i + j, 0);
    end

    // unused misaligned slots ignored
    f[0] = 32'h2000; for (int k = 1; k < NF; k++) f[k] = 32'h3004;
    run_case("R4", 1, 256, 32'h0, 0, 0, f, 2, 0);
    f[0] = 32'h2F00; f[1] = 32'h6000;
    run_case("R4", 1, 4352, 32'h0, 0, 0, f, 7, 0);
    // used misaligned slot
    f[0] = 32'h2000; f[1] = 32'h5010;
    run_case("R5", 1, 5000, 32'h0, 0, 0, f, 0, 0);
    // line size bounds
    for (int k = 0; k < NF; k++) f[k] = 32'h0010_0000 + 32'h1000 * (2 * k);
    run_case("R6", 1, 20481, 32'h0, 0, 0, f, 0, 0);
    run_case("R6", 1, 20480, 32'h0, 0, 0, f, 6, 0);
    // five fragments too small
    for (int k = 0; k < NF; k++) f[k] = 32'h0020_0F00 + 32'h1000 * k;
    run_case("R7", 1, 4096, 32'h0, 0, 0, f, 0, 0);
    run_case("R7", 1, 1280, 32'h0, 0, 0, f, 3, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule